// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block opens an I2C transfer on behalf of a controller. It takes a target address and a read/write flag and decides from the address value whether to use one-byte (7-bit) or two-byte (10-bit) addressing. It refuses addresses that cannot be sent, issues a START, and then issues the address byte or bytes to a downstream byte engine. Every byte is written with the bus held, so no STOP follows and the data phase can continue on an owned bus.

The byte engine is driven by a one-cycle command strobe carrying an operation code and a byte. It answers each command with a one-cycle response strobe and a result code. Only one command is outstanding at a time. When the address phase ends, the block raises `done` for one cycle together with a 2-bit status.

Top module: `i2c_addr_phase_seq`

## Requirements
- R1: An address below 0x80 is sent as a single byte equal to {addr[6:0], read}, with the read flag in bit 0.
- R2: An address below 0x80 whose bits [6:3] are all 1 is rejected. The block issues no engine command and reports status 11 with `done` on the cycle after `go` is accepted.
- R3: An address of 0x400 or above is rejected the same way as in R2: no command, and status 11 on the cycle after `go`.
- R4: An address from 0x80 to 0x3FF is sent as two bytes. The first is {4'b1111, 1'b0, addr[9:7]}. The second is {addr[6:0], read}.
- R5: Before the first address byte, the block issues one START command (op 00). The result of the START is ignored, so only byte results decide the status.
- R6: With 10-bit addressing, the second byte is issued only if the first byte's result is 00 (acknowledged). Otherwise the block ends with the first byte's status and no further command.
- R7: Status reports the result of the last byte sent, coded 00 OK, 01 NACK and 10 timeout. An engine result code of 11 is reported as timeout.
- R8: Every address byte uses op 01 (write, keep bus). The block never issues op 10 (write, then STOP).
- R9: `done` is a one-cycle pulse, given once per accepted request. `busy` is high from the cycle after `go` is accepted through the `done` cycle. A `go` while `busy` is high is ignored.
- R10: After reset, `busy`, `done` and `eng_cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Request strobe, accepted when not busy |
| req_addr | input | REQ_W (11) | Target address |
| req_read | input | 1 | 1 = read transfer, 0 = write |
| busy | output | 1 | Address phase in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 OK, 01 NACK, 10 timeout, 11 invalid address |
| eng_cmd_valid | output | 1 | One-cycle command strobe to the byte engine |
| eng_cmd_op | output | 2 | 00 START, 01 write keep bus, 10 write then STOP |
| eng_cmd_byte | output | 8 | Byte to write |
| eng_rsp_valid | input | 1 | One-cycle response strobe from the engine |
| eng_rsp_code | input | 2 | Engine result: 00 ack, 01 nack, 10 timeout |

## Verification
The embedded assertions check four things on every cycle:
- `done` lasts one cycle and only while `busy` is high.
- No write-with-STOP is ever issued.
- A byte write is always preceded by a START in the same request.
- A rejected address produces an immediate invalid report with no command, and a failed first byte of a 10-bit sequence ends the phase at once.

Only the directed scenarios show the following:
- The exact byte values for 7-bit and 10-bit framing.
- That a failed START does not change the status.
- That each engine result maps to the right status.
- That a `go` arriving mid-phase leaves the command stream untouched.

// File: rtl/i2c_aps_pkg.sv
// Package: shared codes for the address phase sequencer.
// Assumes a 2-bit engine op code and a 2-bit result/status code.
package i2c_aps_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR10_W   = 10;
    localparam logic [3:0] TEN_PREFIX = 4'hF;

    typedef enum logic [1:0] {
        OP_START      = 2'b00,
        OP_WR_HOLD    = 2'b01,
        OP_WR_STOP    = 2'b10,
        OP_RSVD       = 2'b11
    } eng_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_NACK    = 2'b01,
        ST_TIMEOUT = 2'b10,
        ST_INVALID = 2'b11
    } phase_status_e;

    // Map an engine result code onto the reported status (11 folds to timeout).
    function automatic phase_status_e map_rsp(input logic [1:0] code);
        case (code)
            2'b00:   map_rsp = ST_OK;
            2'b01:   map_rsp = ST_NACK;
            default: map_rsp = ST_TIMEOUT;
        endcase
    endfunction

endpackage

// File: rtl/aps_addr_former.sv
// Module: aps_addr_former
// Combinational classifier and byte builder for one requested address.
// It flags addresses that are out of range or that alias the 10-bit prefix,
// and it selects 7-bit or 10-bit framing. It forms both address bytes.
// Assumes REQ_W >= 10.
module aps_addr_former
    import i2c_aps_pkg::*;
#(
    parameter int REQ_W = 11
) (
    input  logic [REQ_W-1:0]  addr,
    input  logic              rd,
    output logic              bad,
    output logic              ten_bit,
    output logic [BYTE_W-1:0] byte_a,
    output logic [BYTE_W-1:0] byte_b
);

    logic [ADDR10_W-1:0] a10;
    logic                over;
    logic                short_form;
    logic                alias_hit;

    assign a10 = addr[ADDR10_W-1:0];

    // Detect set bits above the 10-bit address space, if the port has any.
    generate
        if (REQ_W > ADDR10_W) begin : g_over
            assign over = |addr[REQ_W-1:ADDR10_W];
        end else begin : g_no_over
            assign over = 1'b0;
        end
    endgenerate

    // Classify the address and build the bytes.
    always_comb begin
        short_form = (a10[9:7] == 3'b000) && !over;
        alias_hit  = short_form && (a10[6:3] == 4'hF);
        bad        = over || alias_hit;
        ten_bit    = !short_form;
        byte_b     = {a10[6:0], rd};
        byte_a     = short_form ? {a10[6:0], rd} : {TEN_PREFIX, 1'b0, a10[9:7]};
    end

endmodule

// File: rtl/aps_seq_fsm.sv
// Module: aps_seq_fsm
// Sequences START, the first address byte and the optional second byte.
// It captures the byte results and reports completion.
// Assumes the engine accepts a command on the cycle it is strobed and
// answers with exactly one response strobe per command.
module aps_seq_fsm
    import i2c_aps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              bad,
    input  logic              ten_bit,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_code,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte
);

    typedef enum logic [2:0] {
        S_IDLE, S_ISS_START, S_WT_START, S_ISS_B1, S_WT_B1,
        S_ISS_B2, S_WT_B2, S_REPORT
    } seq_state_e;

    seq_state_e        st;
    logic [BYTE_W-1:0] b1_q;
    logic [BYTE_W-1:0] b2_q;
    logic              ten_q;
    phase_status_e     status_q;

    // State, captured bytes and status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            b1_q     <= '0;
            b2_q     <= '0;
            ten_q    <= 1'b0;
            status_q <= ST_OK;
        end else begin
            case (st)
                S_IDLE: if (go) begin
                    if (bad) begin
                        status_q <= ST_INVALID;
                        st       <= S_REPORT;
                    end else begin
                        b1_q  <= byte_a;
                        b2_q  <= byte_b;
                        ten_q <= ten_bit;
                        st    <= S_ISS_START;
                    end
                end
                S_ISS_START: st <= S_WT_START;
                S_WT_START:  if (rsp_valid) st <= S_ISS_B1;
                S_ISS_B1:    st <= S_WT_B1;
                S_WT_B1: if (rsp_valid) begin
                    if (ten_q && map_rsp(rsp_code) == ST_OK) begin
                        st <= S_ISS_B2;
                    end else begin
                        status_q <= map_rsp(rsp_code);
                        st       <= S_REPORT;
                    end
                end
                S_ISS_B2:    st <= S_WT_B2;
                S_WT_B2: if (rsp_valid) begin
                    status_q <= map_rsp(rsp_code);
                    st       <= S_REPORT;
                end
                default:     st <= S_IDLE;
            endcase
        end
    end

    // Decode the outputs from the state.
    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_REPORT);
        status    = status_q;
        cmd_valid = (st == S_ISS_START) || (st == S_ISS_B1) || (st == S_ISS_B2);
        cmd_op    = (st == S_ISS_START) ? OP_START : OP_WR_HOLD;
        case (st)
            S_ISS_B1: cmd_byte = b1_q;
            S_ISS_B2: cmd_byte = b2_q;
            default:  cmd_byte = '0;
        endcase
    end

    // Assertion support: remember whether START has gone out in this request.
    logic start_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                              start_seen <= 1'b0;
        else if (done)                           start_seen <= 1'b0;
        else if (cmd_valid && cmd_op == OP_START) start_seen <= 1'b1;
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_no_stop_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != OP_WR_STOP));

    p_start_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WR_HOLD) |-> start_seen);

    // Covers R2 and R3: a rejected address reports at once with no command.
    p_invalid_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && go && bad) |=> (done && status == ST_INVALID && !cmd_valid));

    p_first_fail_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WT_B1 && rsp_valid && rsp_code != 2'b00) |=> (done && !cmd_valid));

endmodule

// File: rtl/i2c_addr_phase_seq.sv
// Module: i2c_addr_phase_seq (top)
// Forms the address phase of an I2C transfer in front of a byte engine.
// The address is classified and framed on the cycle go is accepted.
// Commands then go out one at a time.
// Assumes REQ_W >= 10.
module i2c_addr_phase_seq
    import i2c_aps_pkg::*;
#(
    parameter int REQ_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [REQ_W-1:0] req_addr,
    input  logic             req_read,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic             eng_cmd_valid,
    output logic [1:0]       eng_cmd_op,
    output logic [7:0]       eng_cmd_byte,
    input  logic             eng_rsp_valid,
    input  logic [1:0]       eng_rsp_code
);

    logic              bad;
    logic              ten_bit;
    logic [BYTE_W-1:0] byte_a;
    logic [BYTE_W-1:0] byte_b;

    aps_addr_former #(.REQ_W(REQ_W)) former_i (
        .addr    (req_addr),
        .rd      (req_read),
        .bad     (bad),
        .ten_bit (ten_bit),
        .byte_a  (byte_a),
        .byte_b  (byte_b)
    );

    aps_seq_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .bad       (bad),
        .ten_bit   (ten_bit),
        .byte_a    (byte_a),
        .byte_b    (byte_b),
        .rsp_valid (eng_rsp_valid),
        .rsp_code  (eng_rsp_code),
        .busy      (busy),
        .done      (done),
        .status    (status),
        .cmd_valid (eng_cmd_valid),
        .cmd_op    (eng_cmd_op),
        .cmd_byte  (eng_cmd_byte)
    );

endmodule

// File: tb/i2c_addr_phase_seq_tb_top.sv
// Directed bench with a byte engine stub that answers each command after a fixed latency.
module i2c_addr_phase_seq_tb_top;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [10:0] req_addr = '0;
    logic        req_read = 1'b0;
    logic        busy, done;
    logic [1:0]  status;
    logic        eng_cmd_valid;
    logic [1:0]  eng_cmd_op;
    logic [7:0]  eng_cmd_byte;
    logic        eng_rsp_valid = 1'b0;
    logic [1:0]  eng_rsp_code = 2'b00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Stub state
    logic [1:0] plan [0:3];
    logic [1:0] log_op [0:7];
    logic [7:0] log_byte [0:7];
    int log_n = 0;
    int pend_cnt = 0;
    int pend_idx = 0;
    int done_cnt = 0;
    logic [1:0] last_status = 2'b00;

    always #5 clk = ~clk;

    i2c_addr_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .req_addr(req_addr), .req_read(req_read),
        .busy(busy), .done(done), .status(status),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_op(eng_cmd_op), .eng_cmd_byte(eng_cmd_byte),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_code(eng_rsp_code)
    );

    // Engine stub and observers, all acting at the falling edge.
    always @(negedge clk) begin
        cycles++;
        eng_rsp_valid = 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                eng_rsp_valid = 1'b1;
                eng_rsp_code  = (pend_idx < 4) ? plan[pend_idx] : 2'b00;
            end
        end
        if (rst_n && eng_cmd_valid) begin
            if (log_n < 8) begin
                log_op[log_n]   = eng_cmd_op;
                log_byte[log_n] = eng_cmd_byte;
            end
            pend_idx = log_n;
            log_n++;
            pend_cnt = LAT;
        end
        if (rst_n && done) begin
            done_cnt++;
            last_status = status;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_plan(input logic [1:0] c0, input logic [1:0] c1,
                            input logic [1:0] c2, input logic [1:0] c3);
        plan[0] = c0; plan[1] = c1; plan[2] = c2; plan[3] = c3;
    endtask

    // Issue one request and wait until done has been seen.
    task automatic run_req(input logic [10:0] a, input logic rd);
        int d0;
        d0 = done_cnt;
        log_n = 0;
        @(negedge clk);
        req_addr = a; req_read = rd; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 200 && done_cnt == d0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check_eq("R10 busy after reset", int'(busy), 0);
        check_eq("R10 done after reset", int'(done), 0);
        check_eq("R10 cmd_valid after reset", int'(eng_cmd_valid), 0);
    endtask

    task automatic t_seven_bit();
        int d0;
        set_plan(2'b00, 2'b00, 2'b00, 2'b00);
        d0 = done_cnt;
        run_req(11'h050, 1'b0);
        check_eq("R5 command count 7-bit", log_n, 2);
        check_eq("R5 first op START", int'(log_op[0]), 0);
        check_eq("R8 byte op write-hold", int'(log_op[1]), 1);
        check_eq("R1 byte 0x50 write", int'(log_byte[1]), 'hA0);
        check_eq("R7 status ok", int'(last_status), 0);
        check_eq("R9 one done", done_cnt - d0, 1);
        set_plan(2'b00, 2'b01, 2'b00, 2'b00);
        run_req(11'h03C, 1'b1);
        check_eq("R1 byte 0x3C read", int'(log_byte[1]), 'h79);
        check_eq("R7 status nack", int'(last_status), 1);
        set_plan(2'b00, 2'b11, 2'b00, 2'b00);
        run_req(11'h012, 1'b0);
        check_eq("R7 code 11 as timeout", int'(last_status), 2);
    endtask

    task automatic t_invalid();
        int d0;
        set_plan(2'b00, 2'b00, 2'b00, 2'b00);
        d0 = done_cnt;
        run_req(11'h07A, 1'b0);
        check_eq("R2 no command for 0x7A", log_n, 0);
        check_eq("R2 status invalid 0x7A", int'(last_status), 3);
        run_req(11'h078, 1'b1);
        check_eq("R2 no command for 0x78", log_n, 0);
        check_eq("R2 status invalid 0x78", int'(last_status), 3);
        run_req(11'h400, 1'b0);
        check_eq("R3 no command for 0x400", log_n, 0);
        check_eq("R3 status invalid 0x400", int'(last_status), 3);
        run_req(11'h7FF, 1'b0);
        check_eq("R3 status invalid 0x7FF", int'(last_status), 3);
        check_eq("R9 done per rejected request", done_cnt - d0, 4);
        // Timing: done must follow the accepting edge directly.
        @(negedge clk);
        req_addr = 11'h07F; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check_eq("R2 done on cycle after go", int'(done), 1);
        check_eq("R2 status on that cycle", int'(status), 3);
        @(negedge clk);
        check_eq("R9 done lasts one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ten_bit();
        set_plan(2'b00, 2'b00, 2'b00, 2'b00);
        run_req(11'h2A5, 1'b0);
        check_eq("R4 command count 10-bit", log_n, 3);
        check_eq("R4 first byte 0x2A5", int'(log_byte[1]), 'hF5);
        check_eq("R4 second byte 0x2A5", int'(log_byte[2]), 'h4A);
        check_eq("R8 second byte op", int'(log_op[2]), 1);
        check_eq("R7 status ok 10-bit", int'(last_status), 0);
        set_plan(2'b00, 2'b00, 2'b01, 2'b00);
        run_req(11'h080, 1'b1);
        check_eq("R4 first byte 0x080 read", int'(log_byte[1]), 'hF1);
        check_eq("R4 second byte 0x080 read", int'(log_byte[2]), 'h01);
        check_eq("R7 status from second byte", int'(last_status), 1);
        set_plan(2'b00, 2'b00, 2'b10, 2'b00);
        run_req(11'h3FF, 1'b0);
        check_eq("R7 second byte timeout", int'(last_status), 2);
    endtask

    task automatic t_first_fail();
        set_plan(2'b00, 2'b01, 2'b00, 2'b00);
        run_req(11'h155, 1'b0);
        check_eq("R6 no second byte after nack", log_n, 2);
        check_eq("R6 status nack", int'(last_status), 1);
        set_plan(2'b00, 2'b10, 2'b00, 2'b00);
        run_req(11'h200, 1'b1);
        check_eq("R6 no second byte after timeout", log_n, 2);
        check_eq("R6 status timeout", int'(last_status), 2);
    endtask

    task automatic t_start_ignored();
        set_plan(2'b10, 2'b00, 2'b00, 2'b00);
        run_req(11'h021, 1'b0);
        check_eq("R5 start timeout ignored status", int'(last_status), 0);
        check_eq("R5 byte still sent", log_n, 2);
        set_plan(2'b01, 2'b00, 2'b00, 2'b00);
        run_req(11'h181, 1'b0);
        check_eq("R5 start nack ignored 10-bit", log_n, 3);
        check_eq("R5 start nack ignored status", int'(last_status), 0);
    endtask

    task automatic t_go_while_busy();
        int d0;
        set_plan(2'b00, 2'b00, 2'b00, 2'b00);
        d0 = done_cnt;
        log_n = 0;
        @(negedge clk);
        req_addr = 11'h050; req_read = 1'b0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check_eq("R9 busy after go", int'(busy), 1);
        @(negedge clk);
        req_addr = 11'h07A; go = 1'b1;
        @(negedge clk);
        req_addr = 11'h300; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 200 && done_cnt == d0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check_eq("R9 one done despite extra go", done_cnt - d0, 1);
        check_eq("R9 command count unchanged", log_n, 2);
        check_eq("R9 byte from first request", int'(log_byte[1]), 'hA0);
        check_eq("R9 status of first request", int'(last_status), 0);
        check_eq("R9 idle afterwards", int'(busy), 0);
    endtask

    initial begin
        set_plan(2'b00, 2'b00, 2'b00, 2'b00);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_seven_bit();
        t_invalid();
        t_ten_bit();
        t_first_fail();
        t_start_ignored();
        t_go_while_busy();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule